// File: doc/BRIEF.md
# Zero-Suppressing Multichannel Acquisition Sequencer

This block runs one acquisition cycle for a set of peak-held analog channels. A gate pulse arms peak tracking. The gate's falling edge raises busy and starts a programmable settling delay. After the delay, the block asks a sample interface for the held value of every enabled channel, one channel at a time. That interface stands in for the analog multiplexer and converter. Each returned value is tested against a low and a high threshold. The values that pass are packed into tagged words and pushed into an output FIFO.

Zero suppression works per event: an event produces FIFO words only when at least one channel falls inside the window. The packet opens with a header that carries the event number and the channel count. Because the count must be known before the header goes out, the block first completes a scan and keeps the accepted samples, and only then writes. A fast-clear pulse during the settling delay drops the event without a trace. In the other mode, the same pin acts as a reset of the event counter and of the loaded configuration.

Top module: `zs_acq_seq`

## Requirements
- R1: A rising edge on `gate_i` is accepted only while `busy_o` is low and the loaded channel mask has at least one bit set. An accepted gate drives `peak_track_o` high until the gate falls. Any other rising edge, including one that arrives while busy, has no effect.
- R2: The cycle after the accepted gate falls, `busy_o` goes high. It stays high until the event has been fully handled, whether by a packet write, by a completed scan with no qualifying channel, or by an abort.
- R3: The settling delay is `(700 + 500*code)/CLK_NS` cycles. It is measured from the first cycle that `busy_o` is high to the first cycle that `smp_req_o` is high, with channel 0 enabled. Codes above 8 act as 8. With a 5 ns clock, code 0 gives 140 cycles and code 2 gives 340.
- R4: A channel qualifies only when it is enabled and the upper 8 bits of its 12-bit sample lie strictly above `thr_lo_i` and strictly below `thr_hi_i`. A sample equal to either threshold is rejected. Disabled channels are never requested.
- R5: When at least one channel qualifies, the first word written is a header. Its bit 15 is 1, bits 14..3 hold the 12-bit event counter value before the increment, and bits 2..0 hold the number of qualifying channels minus one.
- R6: Every qualifying channel then writes one word: bit 15 is 0, bits 14..12 hold the channel number, and bits 11..0 hold the sample. These words follow the header in ascending channel order.
- R7: When no channel qualifies, nothing is written, but the event counter still increments by one at the end of the sequence.
- R8: With `fc_mode_i` high, a pulse on `rst_pulse_i` during the settling delay aborts the event. `busy_o` drops the next cycle, nothing is written and the event counter is unchanged.
- R9: With `fc_mode_i` low, a pulse on `rst_pulse_i` returns the block to idle. It clears the event counter, the channel mask (so later gates are ignored until a mask is loaded) and the delay code (so the delay becomes the code-0 value).
- R10: While `fifo_hold_i` is high, `busy_o` is high and rising gate edges are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gate_i | input | 1 | Gate pulse (synchronous to clk) |
| rst_pulse_i | input | 1 | Reset or fast-clear pulse |
| fc_mode_i | input | 1 | 1 = the pulse acts as fast clear, 0 = as reset |
| mask_ld_i | input | 1 | Load strobe for the channel mask |
| mask_i | input | 8 | Channel enable mask, bit n enables channel n |
| dly_ld_i | input | 1 | Load strobe for the delay code |
| dly_code_i | input | 4 | Settling delay code |
| thr_lo_i | input | 8 | Low threshold (exclusive) |
| thr_hi_i | input | 8 | High threshold (exclusive) |
| smp_req_o | output | 1 | Sample request, held until acknowledged |
| smp_ch_o | output | 3 | Channel whose sample is requested |
| smp_ack_i | input | 1 | Sample acknowledge, one cycle |
| smp_data_i | input | 12 | Sample value, valid with acknowledge |
| fifo_hold_i | input | 1 | FIFO cannot take a new event |
| fifo_we_o | output | 1 | FIFO write strobe |
| fifo_wdata_o | output | 16 | FIFO write word (header or data) |
| busy_o | output | 1 | Block busy |
| peak_track_o | output | 1 | Peak tracking active (gate accepted and still high) |
| evt_cnt_o | output | 12 | Event counter |

## Verification
A corrupted stored qualify flag or sample shows in the same packet. The header multiplicity, or a data word's channel tag or value, will be wrong at most eight cycles after the scan ends. A faulty event counter or a faulty abort path appears in the next header as a wrong event number, or at once on `evt_cnt_o`. A wrong settling count moves the first sample request away from its computed cycle. Timing of that first request therefore catches any error in the delay arithmetic or in code saturation within a single event.

// File: rtl/zs_acq_pkg.sv
package zs_acq_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_TRACK,
      S_DELAY,
      S_SCAN,
      S_HDR,
      S_DATA,
      S_DONE
   } seq_state_t;

   // settling time in clock cycles for a given (already saturated) code
   function automatic int unsigned settle_cycles(input int unsigned code,
                                                 input int unsigned base_ns,
                                                 input int unsigned step_ns,
                                                 input int unsigned clk_ns);
      return (base_ns + step_ns * code) / clk_ns;
   endfunction

endpackage

// File: rtl/zs_edge_det.sv
module zs_edge_det (
   input  logic clk,
   input  logic rst_n,
   input  logic sig_i,
   output logic rise_o,
   output logic fall_o
);
   logic sig_q;

   always_ff @(posedge clk) begin
      if (!rst_n) sig_q <= 1'b0;
      else        sig_q <= sig_i;
   end

   assign rise_o = sig_i & ~sig_q;
   assign fall_o = ~sig_i & sig_q;
endmodule

// File: rtl/zs_dly_timer.sv
module zs_dly_timer
   import zs_acq_pkg::*;
#(
   parameter int unsigned CODE_W   = 4,
   parameter int unsigned MAX_CODE = 8,
   parameter int unsigned BASE_NS  = 700,
   parameter int unsigned STEP_NS  = 500,
   parameter int unsigned CLK_NS   = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              abort_i,
   input  logic [CODE_W-1:0] code_i,
   output logic              done_o
);
   localparam int unsigned MAX_CYC = settle_cycles(MAX_CODE, BASE_NS, STEP_NS, CLK_NS);
   localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

   if (settle_cycles(0, BASE_NS, STEP_NS, CLK_NS) < 1) begin : g_bad_clk
      $error("zs_dly_timer: clock period too long for the minimum delay");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             run_q;
   logic [CODE_W-1:0] code_sat;
   logic [CNT_W-1:0] load_val;

   always_comb begin
      code_sat = (int'(code_i) > int'(MAX_CODE)) ? CODE_W'(MAX_CODE) : code_i;
      load_val = CNT_W'(settle_cycles(int'(code_sat), BASE_NS, STEP_NS, CLK_NS) - 1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || abort_i) begin
         run_q <= 1'b0;
         cnt_q <= '0;
      end else if (load_i) begin
         run_q <= 1'b1;
         cnt_q <= load_val;
      end else if (run_q) begin
         if (cnt_q == '0) run_q <= 1'b0;
         else             cnt_q <= cnt_q - 1'b1;
      end
   end

   assign done_o = run_q && (cnt_q == '0);
endmodule

// File: rtl/zs_chan_store.sv
module zs_chan_store #(
   parameter int unsigned N_CH  = 8,
   parameter int unsigned SMP_W = 12,
   parameter int unsigned THR_W = 8,
   localparam int unsigned CH_W = $clog2(N_CH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             wr_i,
   input  logic [CH_W-1:0]  wr_ch_i,
   input  logic [SMP_W-1:0] wr_data_i,
   input  logic [THR_W-1:0] thr_lo_i,
   input  logic [THR_W-1:0] thr_hi_i,
   input  logic [CH_W-1:0]  rd_ch_i,
   output logic [SMP_W-1:0] rd_data_o,
   output logic [N_CH-1:0]  qual_o,
   output logic [CH_W:0]    n_qual_o
);
   if (THR_W > SMP_W) begin : g_bad_thr
      $error("zs_chan_store: threshold wider than sample");
   end

   logic [THR_W-1:0] coarse;
   logic             in_win;
   logic [SMP_W-1:0] smp_q [N_CH];
   logic [N_CH-1:0]  qual_q;

   assign coarse = wr_data_i[SMP_W-1 -: THR_W];
   assign in_win = (coarse > thr_lo_i) && (coarse < thr_hi_i);

   for (genvar i = 0; i < N_CH; i++) begin : g_ch
      always_ff @(posedge clk) begin
         if (!rst_n || clr_i) begin
            qual_q[i] <= 1'b0;
            smp_q[i]  <= '0;
         end else if (wr_i && (wr_ch_i == CH_W'(i))) begin
            qual_q[i] <= in_win;
            smp_q[i]  <= wr_data_i;
         end
      end
   end

   always_comb begin
      n_qual_o = '0;
      for (int i = 0; i < N_CH; i++) n_qual_o = n_qual_o + (CH_W+1)'(qual_q[i]);
   end

   assign rd_data_o = smp_q[rd_ch_i];
   assign qual_o    = qual_q;
endmodule

// File: rtl/zs_acq_seq.sv
module zs_acq_seq
   import zs_acq_pkg::*;
#(
   parameter int unsigned N_CH     = 8,
   parameter int unsigned SMP_W    = 12,
   parameter int unsigned THR_W    = 8,
   parameter int unsigned EVT_W    = 12,
   parameter int unsigned CODE_W   = 4,
   parameter int unsigned MAX_CODE = 8,
   parameter int unsigned BASE_NS  = 700,
   parameter int unsigned STEP_NS  = 500,
   parameter int unsigned CLK_NS   = 5,
   localparam int unsigned CH_W    = $clog2(N_CH),
   localparam int unsigned WORD_W  = 1 + EVT_W + CH_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              gate_i,
   input  logic              rst_pulse_i,
   input  logic              fc_mode_i,
   input  logic              mask_ld_i,
   input  logic [N_CH-1:0]   mask_i,
   input  logic              dly_ld_i,
   input  logic [CODE_W-1:0] dly_code_i,
   input  logic [THR_W-1:0]  thr_lo_i,
   input  logic [THR_W-1:0]  thr_hi_i,
   output logic              smp_req_o,
   output logic [CH_W-1:0]   smp_ch_o,
   input  logic              smp_ack_i,
   input  logic [SMP_W-1:0]  smp_data_i,
   input  logic              fifo_hold_i,
   output logic              fifo_we_o,
   output logic [WORD_W-1:0] fifo_wdata_o,
   output logic              busy_o,
   output logic              peak_track_o,
   output logic [EVT_W-1:0]  evt_cnt_o
);
   if (WORD_W != 1 + CH_W + SMP_W) begin : g_bad_word
      $error("zs_acq_seq: header and data words differ in width");
   end
   if (N_CH != (1 << CH_W)) begin : g_bad_nch
      $error("zs_acq_seq: channel count must be a power of two");
   end

   seq_state_t        state_q;
   logic [CH_W-1:0]   ch_q;
   logic [N_CH-1:0]   mask_q;
   logic [CODE_W-1:0] code_q;
   logic [EVT_W-1:0]  evt_q;

   logic gate_rise, gate_fall;
   logic hard_rst, fast_clr, accept, timer_load, timer_done;
   logic ch_last, scan_step;
   logic [SMP_W-1:0] rd_data;
   logic [N_CH-1:0]  qual;
   logic [CH_W:0]    n_qual;

   zs_edge_det u_gate (
      .clk    (clk),
      .rst_n  (rst_n),
      .sig_i  (gate_i),
      .rise_o (gate_rise),
      .fall_o (gate_fall)
   );

   zs_dly_timer #(
      .CODE_W   (CODE_W),
      .MAX_CODE (MAX_CODE),
      .BASE_NS  (BASE_NS),
      .STEP_NS  (STEP_NS),
      .CLK_NS   (CLK_NS)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (timer_load),
      .abort_i (hard_rst | fast_clr),
      .code_i  (code_q),
      .done_o  (timer_done)
   );

   zs_chan_store #(
      .N_CH  (N_CH),
      .SMP_W (SMP_W),
      .THR_W (THR_W)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (accept),
      .wr_i      (state_q == S_SCAN && smp_ack_i && mask_q[ch_q]),
      .wr_ch_i   (ch_q),
      .wr_data_i (smp_data_i),
      .thr_lo_i  (thr_lo_i),
      .thr_hi_i  (thr_hi_i),
      .rd_ch_i   (ch_q),
      .rd_data_o (rd_data),
      .qual_o    (qual),
      .n_qual_o  (n_qual)
   );

   assign hard_rst   = rst_pulse_i && !fc_mode_i;
   assign fast_clr   = rst_pulse_i && fc_mode_i && (state_q == S_DELAY);
   assign accept     = (state_q == S_IDLE) && gate_rise && !fifo_hold_i && (|mask_q);
   assign timer_load = (state_q == S_TRACK) && !gate_i && !hard_rst;
   assign ch_last    = (ch_q == CH_W'(N_CH - 1));
   assign scan_step  = !mask_q[ch_q] || smp_ack_i;

   // configuration held locally so that a reset-mode pulse can clear it
   always_ff @(posedge clk) begin
      if (!rst_n || hard_rst) begin
         mask_q <= '0;
         code_q <= '0;
      end else begin
         if (mask_ld_i) mask_q <= mask_i;
         if (dly_ld_i)  code_q <= dly_code_i;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || hard_rst) begin
         state_q <= S_IDLE;
         ch_q    <= '0;
         evt_q   <= '0;
      end else if (fast_clr) begin
         state_q <= S_IDLE;
      end else begin
         case (state_q)
            S_IDLE:  if (accept) state_q <= S_TRACK;
            S_TRACK: if (!gate_i) state_q <= S_DELAY;
            S_DELAY: if (timer_done) begin
               state_q <= S_SCAN;
               ch_q    <= '0;
            end
            S_SCAN:  if (scan_step) begin
               if (ch_last) state_q <= S_HDR;
               ch_q <= ch_q + 1'b1;
            end
            S_HDR: begin
               state_q <= (n_qual != '0) ? S_DATA : S_DONE;
               ch_q    <= '0;
            end
            S_DATA: begin
               if (ch_last) state_q <= S_DONE;
               ch_q <= ch_q + 1'b1;
            end
            S_DONE: begin
               evt_q   <= evt_q + 1'b1;
               state_q <= S_IDLE;
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      fifo_we_o    = 1'b0;
      fifo_wdata_o = '0;
      if (state_q == S_HDR && n_qual != '0) begin
         fifo_we_o    = 1'b1;
         fifo_wdata_o = {1'b1, evt_q, CH_W'(n_qual - 1'b1)};
      end else if (state_q == S_DATA && qual[ch_q]) begin
         fifo_we_o    = 1'b1;
         fifo_wdata_o = {1'b0, ch_q, rd_data};
      end
   end

   assign smp_req_o    = (state_q == S_SCAN) && mask_q[ch_q];
   assign smp_ch_o     = ch_q;
   assign busy_o       = fifo_hold_i || (state_q != S_IDLE && state_q != S_TRACK);
   assign peak_track_o = (state_q == S_TRACK);
   assign evt_cnt_o    = evt_q;

   // gate_fall is kept for edge symmetry; the sequence keys off the level
   logic unused_fall;
   assign unused_fall = gate_fall;
endmodule

// File: rtl/zs_acq_seq_chk.sv
module zs_acq_seq_chk #(
   parameter int unsigned CH_W   = 3,
   parameter int unsigned EVT_W  = 12,
   parameter int unsigned WORD_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rst_pulse_i,
   input logic              fc_mode_i,
   input logic              mask_ld_i,
   input logic              smp_req_o,
   input logic [CH_W-1:0]   smp_ch_o,
   input logic              smp_ack_i,
   input logic              fifo_we_o,
   input logic [WORD_W-1:0] fifo_wdata_o,
   input logic              busy_o,
   input logic              peak_track_o,
   input logic [EVT_W-1:0]  evt_cnt_o
);
   localparam int unsigned TAG_HI = WORD_W - 2;
   localparam int unsigned TAG_LO = WORD_W - 1 - CH_W;

   a_r1_accept_when_free: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(peak_track_o) |-> $past(!busy_o));

   a_r2_busy_on_trailing: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(peak_track_o) && !$past(rst_pulse_i)) |-> busy_o);

   a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_req_o && !smp_ack_i && !rst_pulse_i && !mask_ld_i) |=> (smp_req_o && $stable(smp_ch_o)));

   a_r4_req_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
      smp_req_o |-> busy_o);

   a_r7_write_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_we_o |-> (busy_o && !smp_req_o && !peak_track_o));

   a_r6_ascending: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_we_o && !fifo_wdata_o[WORD_W-1] && $past(fifo_we_o) && !$past(fifo_wdata_o[WORD_W-1]))
      |-> (fifo_wdata_o[TAG_HI:TAG_LO] > $past(fifo_wdata_o[TAG_HI:TAG_LO])));

   a_r9_reset_clears_count: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_pulse_i && !fc_mode_i) |=> (evt_cnt_o == '0));
endmodule

bind zs_acq_seq zs_acq_seq_chk #(
   .CH_W   (CH_W),
   .EVT_W  (EVT_W),
   .WORD_W (WORD_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .rst_pulse_i  (rst_pulse_i),
   .fc_mode_i    (fc_mode_i),
   .mask_ld_i    (mask_ld_i),
   .smp_req_o    (smp_req_o),
   .smp_ch_o     (smp_ch_o),
   .smp_ack_i    (smp_ack_i),
   .fifo_we_o    (fifo_we_o),
   .fifo_wdata_o (fifo_wdata_o),
   .busy_o       (busy_o),
   .peak_track_o (peak_track_o),
   .evt_cnt_o    (evt_cnt_o)
);

// File: tb/sim_zs_acq_seq.sv
`timescale 1ns/1ps
module sim_zs_acq_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        gate_i = 1'b0, rst_pulse_i = 1'b0, fc_mode_i = 1'b0;
   logic        mask_ld_i = 1'b0, dly_ld_i = 1'b0;
   logic [7:0]  mask_i = '0, thr_lo_i = '0, thr_hi_i = '0;
   logic [3:0]  dly_code_i = '0;
   logic        smp_req_o, smp_ack_i, fifo_hold_i = 1'b0, fifo_we_o, busy_o, peak_track_o;
   logic [2:0]  smp_ch_o;
   logic [11:0] smp_data_i, evt_cnt_o;
   logic [15:0] fifo_wdata_o;

   int checks = 0, fails = 0, cyc = 0, exp_evt = 0, ncap = 0;
   logic        cap_clr = 1'b0;
   logic [15:0] cap [64];
   logic [11:0] pk [8];

   always #2.5 clk = ~clk;

   zs_acq_seq u0 (.*);

   // sample source: acknowledge one cycle after a request
   always @(posedge clk) begin
      if (!rst_n) smp_ack_i <= 1'b0;
      else        smp_ack_i <= smp_req_o && !smp_ack_i;
      smp_data_i <= pk[smp_ch_o];
   end

   always @(posedge clk) begin
      if (cap_clr) ncap <= 0;
      else if (fifo_we_o && ncap < 64) begin
         cap[ncap] <= fifo_wdata_o;
         ncap <= ncap + 1;
      end
   end

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         fails = fails + 1;
         $display("FAIL watchdog: actual=%0d expected<150000", cyc);
         finish_run();
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic load_mask(input logic [7:0] m);
      @(negedge clk); mask_i = m; mask_ld_i = 1'b1;
      @(negedge clk); mask_ld_i = 1'b0;
   endtask

   task automatic load_dly(input logic [3:0] c);
      @(negedge clk); dly_code_i = c; dly_ld_i = 1'b1;
      @(negedge clk); dly_ld_i = 1'b0;
   endtask

   task automatic clear_cap();
      @(negedge clk); cap_clr = 1'b1;
      @(negedge clk); cap_clr = 1'b0;
   endtask

   // accepted gate, then measure settling delay and wait for the end
   task automatic fire_gate(output int d);
      int w;
      @(negedge clk); gate_i = 1'b1;
      repeat (4) @(negedge clk);
      chk(peak_track_o === 1'b1, "R1 track during gate", int'(peak_track_o), 1);
      chk(busy_o === 1'b0, "R2 not busy during gate", int'(busy_o), 0);
      gate_i = 1'b0;
      @(negedge clk);
      chk(busy_o === 1'b1, "R2 busy after trailing edge", int'(busy_o), 1);
      d = 0;
      while (!smp_req_o && d < 3000) begin @(negedge clk); d++; end
      w = 0;
      while (busy_o && w < 5000) begin @(negedge clk); w++; end
      chk(busy_o === 1'b0, "R2 busy released", int'(busy_o), 0);
   endtask

   task automatic run_vec(input logic [7:0] m, input logic [7:0] lo, input logic [7:0] hi,
                          input logic [63:0] pv);
      logic [15:0] ex [9];
      int n = 0, d;
      for (int i = 0; i < 8; i++) pk[i] = {pv[i*8 +: 8], 4'(i)};
      thr_lo_i = lo; thr_hi_i = hi;
      load_mask(m);
      clear_cap();
      for (int i = 0; i < 8; i++)
         if (m[i] && pv[i*8 +: 8] > lo && pv[i*8 +: 8] < hi) begin
            ex[n+1] = {1'b0, 3'(i), pk[i]};
            n++;
         end
      ex[0] = {1'b1, 12'(exp_evt), 3'(n - 1)};
      fire_gate(d);
      @(negedge clk);
      // R4/R7: word count, zero when nothing qualifies
      chk(ncap == ((n > 0) ? n + 1 : 0), "R4 R7 word count", ncap, (n > 0) ? n + 1 : 0);
      if (n > 0) begin
         chk(cap[0] == ex[0], "R5 header", int'(cap[0]), int'(ex[0]));
         for (int k = 1; k <= n; k++)
            chk(cap[k] == ex[k], "R6 data word", int'(cap[k]), int'(ex[k]));
      end
      exp_evt++;
      chk(evt_cnt_o == 12'(exp_evt), "R7 event count", int'(evt_cnt_o), exp_evt);
   endtask

   // {mask, lo, hi, peaks(ch7..ch0)}
   localparam logic [87:0] VEC [6] = '{
      {8'hFF, 8'h10, 8'hC0, 64'hFFBF1110C0800520},
      {8'h24, 8'h10, 8'hC0, 64'h5050505050505050},
      {8'h0F, 8'h40, 8'h60, 64'h3030303030303030},
      {8'hFF, 8'h00, 8'hFF, 64'h8080808080808080},
      {8'h80, 8'h00, 8'hFF, 64'h0101010101010101},
      {8'h0B, 8'h10, 8'h90, 64'h0000000050508F11}
   };

   initial begin
      int d, ev0;
      for (int i = 0; i < 8; i++) pk[i] = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy_o === 1'b0 && fifo_we_o === 1'b0, "R2 reset idle", int'(busy_o), 0);
      chk(evt_cnt_o == 0, "R9 reset count", int'(evt_cnt_o), 0);

      // R1: no enabled channel, gate ignored
      @(negedge clk); gate_i = 1'b1;
      repeat (3) @(negedge clk);
      chk(peak_track_o === 1'b0 && busy_o === 1'b0, "R1 empty mask ignored", int'(peak_track_o), 0);
      gate_i = 1'b0;

      // table of events: R4 R5 R6 R7
      for (int v = 0; v < 6; v++)
         run_vec(VEC[v][87:80], VEC[v][79:72], VEC[v][71:64], VEC[v][63:0]);

      // R3 settling delay
      for (int i = 0; i < 8; i++) pk[i] = 12'h500;
      thr_lo_i = 8'h10; thr_hi_i = 8'hC0;
      load_mask(8'h01);
      load_dly(4'd2);
      fire_gate(d); exp_evt++;
      chk(d == (700 + 500*2)/5, "R3 delay code 2", d, (700 + 500*2)/5);
      load_dly(4'd12);
      fire_gate(d); exp_evt++;
      chk(d == (700 + 500*8)/5, "R3 delay code saturates", d, (700 + 500*8)/5);

      // R1: gate while busy ignored
      load_dly(4'd0);
      clear_cap();
      @(negedge clk); gate_i = 1'b1;
      repeat (3) @(negedge clk);
      gate_i = 1'b0;
      repeat (10) @(negedge clk);
      chk(busy_o === 1'b1, "R2 busy in delay", int'(busy_o), 1);
      gate_i = 1'b1;
      repeat (3) @(negedge clk);
      chk(peak_track_o === 1'b0, "R1 gate while busy ignored", int'(peak_track_o), 0);
      gate_i = 1'b0;
      while (busy_o) @(negedge clk);
      repeat (2) @(negedge clk);
      exp_evt++;
      chk(evt_cnt_o == 12'(exp_evt), "R1 single event counted", int'(evt_cnt_o), exp_evt);
      chk(ncap == 2, "R1 single packet", ncap, 2);

      // R8 fast clear in delay window
      fc_mode_i = 1'b1;
      clear_cap();
      ev0 = int'(evt_cnt_o);
      @(negedge clk); gate_i = 1'b1;
      repeat (3) @(negedge clk);
      gate_i = 1'b0;
      repeat (20) @(negedge clk);
      rst_pulse_i = 1'b1;
      @(negedge clk); rst_pulse_i = 1'b0;
      chk(busy_o === 1'b0, "R8 busy dropped", int'(busy_o), 0);
      repeat (300) @(negedge clk);
      chk(ncap == 0, "R8 nothing written", ncap, 0);
      chk(int'(evt_cnt_o) == ev0, "R8 count unchanged", int'(evt_cnt_o), ev0);

      // R10 FIFO hold
      @(negedge clk); fifo_hold_i = 1'b1;
      @(negedge clk);
      chk(busy_o === 1'b1, "R10 busy under hold", int'(busy_o), 1);
      gate_i = 1'b1;
      repeat (3) @(negedge clk);
      chk(peak_track_o === 1'b0, "R10 gate blocked", int'(peak_track_o), 0);
      gate_i = 1'b0; fifo_hold_i = 1'b0;

      // R9 reset-mode pulse
      load_dly(4'd6);
      fc_mode_i = 1'b0;
      @(negedge clk); rst_pulse_i = 1'b1;
      @(negedge clk); rst_pulse_i = 1'b0;
      chk(evt_cnt_o == 0, "R9 count cleared", int'(evt_cnt_o), 0);
      gate_i = 1'b1;
      repeat (3) @(negedge clk);
      chk(peak_track_o === 1'b0, "R9 mask cleared", int'(peak_track_o), 0);
      gate_i = 1'b0;
      load_mask(8'h01);
      fire_gate(d);
      chk(d == 700/5, "R9 delay cleared", d, 700/5);

      finish_run();
   end
endmodule